// File: doc/BRIEF.md
# Sixteen-Stage Pseudo-Random Sequence Generator

This block is a 16-stage maximal-length shift-register sequence generator. One parameter picks how the feedback is applied. In the external form, the parity of the tapped stages enters at the left end. In the internal form, the bit leaving the right end is folded into the tapped stages as the register shifts. A second parameter picks plain parity feedback or inverted parity feedback. With inverted feedback, every state is the bitwise complement of the state that plain feedback gives.

The register always shifts toward bit 0. Bit 0 is the serial output. The state moves on one step only in cycles where the advance enable is high. A seed may be loaded at any time, and a load wins over an advance. The generator cannot stall in its lock-up state. That state is all zeros with plain feedback and all ones with inverted feedback. Reset places a fixed legal start value in the register. A load of the lock-up value is replaced by that same start value.

Top module: `prbs16_lfsr`

## Requirements
- R1: A clock edge with rst_n low sets state_q to the start value. The start value is 0xACE1 with plain feedback and 0x531E with inverted feedback.
- R2: With seed_load and adv_en both low, state_q keeps its value across the clock edge.
- R3: seed_load high loads seed_val at the next edge, whatever adv_en is, when seed_val is not the lock-up value.
- R4: A load of the lock-up value (0x0000 for plain feedback, 0xFFFF for inverted feedback) stores the start value instead. With plain feedback, a load of 0xFFFF is stored as is. With inverted feedback, a load of 0x0000 is stored as is.
- R5: External form, plain feedback, on an advance: the new bit 15 is the parity of bits 0, 2, 3 and 5, and every other bit takes the value of the bit above it. For example, 0xACE1 becomes 0x5670.
- R6: Internal form, plain feedback, on an advance: the state shifts right by one. If the old bit 0 was 1, the shifted value is XORed with 0xB400. For example, 0xACE1 becomes 0xE270.
- R7: serial_out always equals bit 0 of state_q.
- R8: With inverted feedback, each state equals the complement of the state that plain feedback reaches from the complemented start.
- R9: From any legal seed, the state first returns to that seed after exactly 65535 advances.
- R10: After reset, state_q never holds the lock-up value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_en | input | 1 | Step the sequence by one state |
| seed_load | input | 1 | Load seed_val; has priority over adv_en |
| seed_val | input | 16 | Seed value to load |
| state_q | output | 16 | Current register state |
| serial_out | output | 1 | Bit 0 of the state |

## Verification
Every result goes through one register. A reset, load or advance applied before a rising edge shows on state_q right after that edge, and serial_out follows in the same cycle with no extra delay. The bench drives inputs on the falling edge and updates its behavioural model for the rising edge that follows. It compares all four configurations against that model on the next falling edge, which is exactly one cycle after each stimulus. The period check counts advances from a loaded seed and notes the first return to that seed.

// File: rtl/lfsr_pkg.sv
// Shared types for the sequence generator.
package lfsr_pkg;
    // Selects how the feedback is applied
    typedef enum logic {
        FORM_FIB = 1'b0,   // parity of the taps enters at the left end
        FORM_GAL = 1'b1    // the output bit is folded into the taps during the shift
    } lfsr_form_e;
endpackage

// File: rtl/lfsr_next.sv
// Combinational next-state function of the shift register.
// Assumes: bit 0 of TAP_MASK is set (the output stage is always a tap).
// TAP_MASK is written in external-form positions. The internal form uses
// the mirrored mask, so both forms share one polynomial parameter.
module lfsr_next #(
    parameter int                 WIDTH    = 16,
    parameter logic [WIDTH-1:0]   TAP_MASK = 16'h002D,
    parameter lfsr_pkg::lfsr_form_e FORM   = lfsr_pkg::FORM_FIB,
    parameter bit                 USE_XNOR = 1'b0
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    generate
        if (FORM == lfsr_pkg::FORM_FIB) begin : g_fib
            logic fb;
            // Parity of the tapped stages, inverted for XNOR feedback
            assign fb  = (^(cur & TAP_MASK)) ^ USE_XNOR;
            assign nxt = {fb, cur[WIDTH-1:1]};
        end else begin : g_gal
            logic             gfb;
            logic [WIDTH-1:0] gmask;
            // Output bit drives the internal taps, inverted for XNOR feedback
            assign gfb = cur[0] ^ USE_XNOR;
            for (genvar i = 0; i < WIDTH; i++) begin : g_mask
                assign gmask[i] = TAP_MASK[WIDTH-1-i];
            end
            for (genvar i = 0; i < WIDTH-1; i++) begin : g_stage
                assign nxt[i] = cur[i+1] ^ (gmask[i] & gfb);
            end
            assign nxt[WIDTH-1] = cur[0];
        end
    endgenerate
endmodule

// File: rtl/lfsr_seed_guard.sv
// Replaces a seed equal to the lock-up state with a legal start value.
// Assumes: SAFE_STATE differs from LOCK_STATE.
module lfsr_seed_guard #(
    parameter int               WIDTH      = 16,
    parameter logic [WIDTH-1:0] LOCK_STATE = '0,
    parameter logic [WIDTH-1:0] SAFE_STATE = 16'hACE1
) (
    input  logic [WIDTH-1:0] seed_in,
    output logic [WIDTH-1:0] seed_out
);
    // Pass the seed through unless it would stall the register
    always_comb begin
        seed_out = (seed_in == LOCK_STATE) ? SAFE_STATE : seed_in;
    end
endmodule

// File: rtl/prbs16_lfsr.sv
// Top of the maximal-length sequence generator.
// The register shifts toward bit 0, and bit 0 is the serial output.
// A seed load has priority over an advance. Reset and lock-up loads both
// put the start value in the register.
module prbs16_lfsr #(
    parameter int                   WIDTH     = 16,
    parameter logic [WIDTH-1:0]     TAP_MASK  = 16'h002D,
    parameter lfsr_pkg::lfsr_form_e FORM      = lfsr_pkg::FORM_FIB,
    parameter bit                   USE_XNOR  = 1'b0,
    parameter logic [WIDTH-1:0]     BASE_SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_en,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] seed_val,
    output logic [WIDTH-1:0] state_q,
    output logic             serial_out
);
    localparam logic [WIDTH-1:0] LOCK_STATE = {WIDTH{USE_XNOR}};
    localparam logic [WIDTH-1:0] SAFE_STATE = BASE_SEED ^ {WIDTH{USE_XNOR}};

    logic [WIDTH-1:0] step_val;
    logic [WIDTH-1:0] load_val;

    lfsr_next #(
        .WIDTH(WIDTH), .TAP_MASK(TAP_MASK), .FORM(FORM), .USE_XNOR(USE_XNOR)
    ) u_next (
        .cur(state_q),
        .nxt(step_val)
    );

    lfsr_seed_guard #(
        .WIDTH(WIDTH), .LOCK_STATE(LOCK_STATE), .SAFE_STATE(SAFE_STATE)
    ) u_guard (
        .seed_in (seed_val),
        .seed_out(load_val)
    );

    // State register: reset, then load, then advance, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SAFE_STATE;
        end else if (seed_load) begin
            state_q <= load_val;
        end else if (adv_en) begin
            state_q <= step_val;
        end
    end

    // Serial output taken from the rightmost stage
    assign serial_out = state_q[0];
endmodule

// File: rtl/prbs16_lfsr_chk.sv
// Property checker for prbs16_lfsr, attached with a bind statement.
// Assumes: the first clock edge of interest has rst_n low.
module prbs16_lfsr_chk #(
    parameter int               WIDTH      = 16,
    parameter logic [WIDTH-1:0] LOCK_STATE = '0,
    parameter logic [WIDTH-1:0] SAFE_STATE = 16'hACE1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adv_en,
    input logic             seed_load,
    input logic [WIDTH-1:0] seed_val,
    input logic [WIDTH-1:0] state_q
);
    logic seen_rst = 1'b0;

    // Note once a reset edge has happened
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    p_reset_value_r1: assert property (@(posedge clk)
        (!rst_n) |=> (state_q == SAFE_STATE));

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        (!seed_load && !adv_en) |=> $stable(state_q));

    p_load_seed_r3: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        (seed_load && seed_val != LOCK_STATE) |=> (state_q == $past(seed_val)));

    p_lock_swap_r4: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        (seed_load && seed_val == LOCK_STATE) |=> (state_q == SAFE_STATE));

    p_adv_moves_r5: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        (adv_en && !seed_load) |=> (state_q != $past(state_q)));

    p_no_lockup_r10: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        (state_q != LOCK_STATE));
endmodule

bind prbs16_lfsr prbs16_lfsr_chk #(
    .WIDTH(WIDTH), .LOCK_STATE(LOCK_STATE), .SAFE_STATE(SAFE_STATE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .seed_load(seed_load),
    .seed_val(seed_val), .state_q(state_q)
);

// File: tb/prbs16_lfsr_tb.sv
// Bench: drives four configurations side by side and compares each against
// a behavioural model on every clock.
module prbs16_lfsr_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_en = 1'b0;
    logic        seed_load = 1'b0;
    logic [15:0] seed_val = 16'h0000;
    logic [15:0] st [4];
    logic        so [4];
    logic [15:0] m  [4];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    // Index k: bit 0 = internal form, bit 1 = inverted feedback
    prbs16_lfsr #(.FORM(lfsr_pkg::FORM_FIB), .USE_XNOR(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .seed_load(seed_load),
        .seed_val(seed_val), .state_q(st[0]), .serial_out(so[0]));
    prbs16_lfsr #(.FORM(lfsr_pkg::FORM_GAL), .USE_XNOR(1'b0)) u_dut_gal (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .seed_load(seed_load),
        .seed_val(seed_val), .state_q(st[1]), .serial_out(so[1]));
    prbs16_lfsr #(.FORM(lfsr_pkg::FORM_FIB), .USE_XNOR(1'b1)) u_dut_fxn (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .seed_load(seed_load),
        .seed_val(seed_val), .state_q(st[2]), .serial_out(so[2]));
    prbs16_lfsr #(.FORM(lfsr_pkg::FORM_GAL), .USE_XNOR(1'b1)) u_dut_gxn (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .seed_load(seed_load),
        .seed_val(seed_val), .state_q(st[3]), .serial_out(so[3]));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] plain_step(bit gal, logic [15:0] s);
        int v = int'(s);
        if (!gal) begin
            int p = (v ^ (v >> 2) ^ (v >> 3) ^ (v >> 5)) & 1;
            return 16'((v >> 1) | (p << 15));
        end
        if ((v & 1) != 0) return 16'((v >> 1) ^ 'hB400);
        return 16'(v >> 1);
    endfunction

    function automatic logic [15:0] ref_step(int k, logic [15:0] s);
        if (k >= 2) return ~plain_step(k % 2 == 1, ~s);
        return plain_step(k % 2 == 1, s);
    endfunction

    function automatic logic [15:0] lock_of(int k);
        return (k >= 2) ? 16'hFFFF : 16'h0000;
    endfunction

    function automatic logic [15:0] start_of(int k);
        return (k >= 2) ? 16'h531E : 16'hACE1;
    endfunction

    task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // One cycle: drive at the falling edge, model the rising edge, compare at the next falling edge
    task automatic step(bit rn, bit ld, bit adv, logic [15:0] sv, string req);
        rst_n = rn; seed_load = ld; adv_en = adv; seed_val = sv;
        @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            if (!rn)      m[k] = start_of(k);
            else if (ld)  m[k] = (sv == lock_of(k)) ? start_of(k) : sv;
            else if (adv) m[k] = ref_step(k, m[k]);
        end
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            check(st[k] === m[k], req, st[k], m[k]);
            check(so[k] === m[k][0], "R7", {15'd0, so[k]}, {15'd0, m[k][0]});
            if (rn) check(st[k] !== lock_of(k), "R10", st[k], ~lock_of(k));
        end
    endtask

    initial begin
        bit early [4];
        @(negedge clk);
        step(1'b0, 1'b0, 1'b0, 16'h0, "R1");
        step(1'b0, 1'b1, 1'b1, 16'h1234, "R1");
        check(st[0] == 16'hACE1 && st[2] == 16'h531E, "R1", st[2], 16'h531E);

        step(1'b1, 1'b0, 1'b1, 16'h0, "R5 R6 R8");
        check(st[0] == 16'h5670, "R5", st[0], 16'h5670);
        check(st[1] == 16'hE270, "R6", st[1], 16'hE270);
        check(st[2] == 16'hA98F, "R8", st[2], 16'hA98F);
        check(st[3] == 16'h1D8F, "R8", st[3], 16'h1D8F);

        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 16'h5A5A, "R2");

        step(1'b1, 1'b1, 1'b1, 16'h1234, "R3");
        check(st[1] == 16'h1234, "R3", st[1], 16'h1234);
        step(1'b1, 1'b1, 1'b0, 16'h0000, "R4");
        check(st[0] == 16'hACE1 && st[2] == 16'h0000, "R4", st[0], 16'hACE1);
        step(1'b1, 1'b1, 1'b1, 16'hFFFF, "R4");
        check(st[3] == 16'h531E && st[1] == 16'hFFFF, "R4", st[3], 16'h531E);

        for (int i = 0; i < 300; i++)
            step(1'b1, (i % 37) == 5, (i % 3) != 0, 16'(i * 977 + 3), "R2 R3 R5 R6 R8");
        step(1'b0, 1'b1, 1'b1, 16'h0F0F, "R1");

        // R9: from seed 0xACE1 the state must not repeat before 65535 advances
        step(1'b1, 1'b1, 1'b0, 16'hACE1, "R3");
        for (int k = 0; k < 4; k++) early[k] = 1'b0;
        for (int i = 1; i <= 65535; i++) begin
            step(1'b1, 1'b0, 1'b1, 16'h0, "R5 R6 R8");
            for (int k = 0; k < 4; k++)
                if (i < 65535 && st[k] == 16'hACE1) early[k] = 1'b1;
        end
        for (int k = 0; k < 4; k++) begin
            check(!early[k], "R9", st[k], 16'hACE1);
            check(st[k] == 16'hACE1, "R9", st[k], 16'hACE1);
        end
        done = 1'b1;
        finish_up();
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            finish_up();
        end
    end
endmodule